// File: doc/BRIEF.md
# Tagged Coefficient Result Cache

This block keeps coefficients that an algorithm has already computed, such as transform twiddle factors, so that later uses need not compute them again. Each stored value carries a tag made from an 8-bit algorithm number and three loop indices. Before an algorithm uses the cache it is registered. Registration stores the entry address of the routine that computes a missing value. It also stores how many bits each loop index takes in the tag, from 0 to 8.

A lookup carries a destination register tag, the algorithm number and three indices. One cycle later the block returns exactly one of three results. A hit returns the stored value. A miss returns the routine address held for that algorithm. An error means the algorithm number was never registered. After a miss, the caller computes the value and writes it through the fill port. Registering an algorithm number again drops every value cached under that number, which keeps coefficients from a replaced routine out of use.

Top module: `coef_result_cache`

## Requirements
- R1: After reset, no algorithm number is registered, no value is cached, and rsp_valid is low.
- R2: A request accepted with req_valid high in one cycle produces rsp_valid high in the next cycle, with rsp_dest equal to the request's req_dest. Without a request, rsp_valid is low.
- R3: On a miss, rsp_miss is high, rsp_entry holds the routine address registered for that algorithm number, and rsp_data is 0.
- R4: A lookup whose tag matches a filled entry returns rsp_hit high, with the filled value on rsp_data and rsp_entry at 0.
- R5: The tag key packs the masked indices contiguously: index 0 in the highest position, then index 1, then index 2 in the lowest bits. Each index takes its registered width. Index bits at or above that width are ignored, so stray upper bits still hit.
- R6: A registered width above 8 is treated as 8. A width of 0 makes that index ignored.
- R7: A lookup for an unregistered algorithm number returns rsp_err high, with rsp_data and rsp_entry at 0. A fill for an unregistered number is discarded.
- R8: Registering an algorithm number clears, in the same cycle, every cached entry with that number. Entries of other numbers are kept, and later misses return the new routine address.
- R9: A lookup in the same cycle as a fill of the same tag returns a hit with the fill value.
- R10: The cache has 16 entries. A fill whose tag is already present overwrites that entry in place. Any other fill takes the slot under a round-robin pointer, which then advances, so the 17th new tag evicts the first.
- R11: Every response raises exactly one of rsp_hit, rsp_miss and rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Register an algorithm this cycle |
| cfg_id | input | 8 | Algorithm number to register |
| cfg_entry | input | 32 | Routine entry address |
| cfg_w0 | input | 4 | Bit width of index 0 in the tag |
| cfg_w1 | input | 4 | Bit width of index 1 in the tag |
| cfg_w2 | input | 4 | Bit width of index 2 in the tag |
| req_valid | input | 1 | Lookup request |
| req_dest | input | 6 | Destination register tag, echoed back |
| req_id | input | 8 | Algorithm number of the lookup |
| req_i0 | input | 8 | Loop index 0 |
| req_i1 | input | 8 | Loop index 1 |
| req_i2 | input | 8 | Loop index 2 |
| wr_valid | input | 1 | Fill a computed value |
| wr_id | input | 8 | Algorithm number of the fill |
| wr_i0 | input | 8 | Fill loop index 0 |
| wr_i1 | input | 8 | Fill loop index 1 |
| wr_i2 | input | 8 | Fill loop index 2 |
| wr_data | input | 32 | Value to store |
| rsp_valid | output | 1 | Response present |
| rsp_dest | output | 6 | Echoed destination tag |
| rsp_hit | output | 1 | Value found |
| rsp_miss | output | 1 | Value absent, routine address given |
| rsp_err | output | 1 | Algorithm number not registered |
| rsp_data | output | 32 | Cached value on a hit |
| rsp_entry | output | 32 | Routine address on a miss |

## Verification
The assertions check on every cycle that each request is answered one cycle later with its destination tag, that each response raises exactly one flag, and that an error response carries zeros. They also check that no two valid entries share a tag, and that a registration leaves no entry of that algorithm number valid. Only the bench scenarios can show the rest. These are the exact tag packing with masked and clamped widths, the same-cycle fill bypass, the survival of other algorithms across a re-registration, and round-robin eviction order against in-place overwrite.

// File: rtl/cres_pkg.sv
package cres_pkg;
    localparam int ID_W     = 8;
    localparam int IDX_W    = 8;
    localparam int WID_W    = 4;
    localparam int DATA_W   = 32;
    localparam int ENTRY_W  = 32;
    localparam int DEST_W   = 6;
    localparam int KEY_W    = 3 * IDX_W;
    localparam int NUM_ALGS = 1 << ID_W;

    typedef logic [ID_W-1:0]    alg_id_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WID_W-1:0]   wid_t;
    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef struct packed {
        wid_t w0;
        wid_t w1;
        wid_t w2;
    } pack_cfg_t;

    typedef struct packed {
        entry_t    entry;
        pack_cfg_t cfg;
    } alg_rec_t;

    typedef struct packed {
        logic    vld;
        alg_id_t id;
        key_t    key;
        data_t   data;
    } line_t;

    function automatic wid_t clamp_w(input wid_t w);
        return (w > wid_t'(IDX_W)) ? wid_t'(IDX_W) : w;
    endfunction

    function automatic idx_t mask_idx(input idx_t v, input wid_t w);
        idx_t m;
        m = idx_t'(((IDX_W+1)'(1) << w) - (IDX_W+1)'(1));
        return v & m;
    endfunction

    // Index 0 sits highest, index 2 lowest, each taking its registered width.
    function automatic key_t make_key(input idx_t a, input idx_t b, input idx_t c,
                                      input pack_cfg_t cfg);
        key_t ka, kb, kc;
        ka = key_t'(mask_idx(a, cfg.w0));
        kb = key_t'(mask_idx(b, cfg.w1));
        kc = key_t'(mask_idx(c, cfg.w2));
        return (ka << ({1'b0, cfg.w1} + {1'b0, cfg.w2})) | (kb << cfg.w2) | kc;
    endfunction
endpackage

// File: rtl/cres_alg_table.sv
module cres_alg_table
    import cres_pkg::*;
#(
    parameter int N_ALGS = NUM_ALGS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     set_en,
    input  alg_id_t  set_id,
    input  alg_rec_t set_rec,
    input  alg_id_t  rda_id,
    output logic     rda_known,
    output alg_rec_t rda_rec,
    input  alg_id_t  rdb_id,
    output logic     rdb_known,
    output alg_rec_t rdb_rec
);
    logic [N_ALGS-1:0] known_q;
    alg_rec_t          rec_q [N_ALGS];

    always_ff @(posedge clk) begin
        if (rst)
            known_q <= '0;
        else if (set_en)
            known_q[set_id] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (set_en)
            rec_q[set_id] <= set_rec;
    end

    assign rda_known = known_q[rda_id];
    assign rda_rec   = rec_q[rda_id];
    assign rdb_known = known_q[rdb_id];
    assign rdb_rec   = rec_q[rdb_id];
endmodule

// File: rtl/cres_tag_store.sv
module cres_tag_store
    import cres_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  alg_id_t lk_id,
    input  key_t    lk_key,
    output logic    lk_hit,
    output data_t   lk_data,
    input  logic    fill_en,
    input  alg_id_t fill_id,
    input  key_t    fill_key,
    input  data_t   fill_data,
    input  logic    inv_en,
    input  alg_id_t inv_id
);
    localparam int PTR_W = $clog2(ENTRIES);

    line_t             line_q [ENTRIES];
    logic [PTR_W-1:0]  ptr_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic              fill_present;
    logic [PTR_W-1:0]  fill_slot;
    logic [PTR_W-1:0]  tgt_slot;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = line_q[g].vld && line_q[g].id == lk_id   && line_q[g].key == lk_key;
        assign fill_match[g] = line_q[g].vld && line_q[g].id == fill_id && line_q[g].key == fill_key;
    end

    assign lk_hit       = |lk_match;
    assign fill_present = |fill_match;

    always_comb begin
        lk_data   = '0;
        fill_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i])
                lk_data = lk_data | line_q[i].data;
            if (fill_match[i])
                fill_slot = PTR_W'(i);
        end
        tgt_slot = fill_present ? fill_slot : ptr_q;
    end

    // Invalidation is applied first; a fill in the same cycle lands after it.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < ENTRIES; i++)
                line_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_en && line_q[i].id == inv_id)
                    line_q[i].vld <= 1'b0;
                if (fill_en && tgt_slot == PTR_W'(i))
                    line_q[i] <= '{vld: 1'b1, id: fill_id, key: fill_key, data: fill_data};
            end
            if (fill_en && !fill_present)
                ptr_q <= (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Checker state for the bulk-invalidation property.
    logic               chk_inv_q;
    logic               chk_fill_q;
    alg_id_t            chk_id_q;
    logic [ENTRIES-1:0] stale;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_inv_q  <= 1'b0;
            chk_fill_q <= 1'b0;
            chk_id_q   <= '0;
        end else begin
            chk_inv_q  <= inv_en;
            chk_fill_q <= fill_en && fill_id == inv_id;
            chk_id_q   <= inv_id;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_stale
        assign stale[g] = line_q[g].vld && line_q[g].id == chk_id_q;
    end

    // R10
    unique_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R8
    bulk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_inv_q && !chk_fill_q) |-> (stale == '0));
endmodule

// File: rtl/coef_result_cache.sv
module coef_result_cache
    import cres_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_valid,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic [ENTRY_W-1:0] cfg_entry,
    input  logic [WID_W-1:0]   cfg_w0,
    input  logic [WID_W-1:0]   cfg_w1,
    input  logic [WID_W-1:0]   cfg_w2,
    input  logic               req_valid,
    input  logic [DEST_W-1:0]  req_dest,
    input  logic [ID_W-1:0]    req_id,
    input  logic [IDX_W-1:0]   req_i0,
    input  logic [IDX_W-1:0]   req_i1,
    input  logic [IDX_W-1:0]   req_i2,
    input  logic               wr_valid,
    input  logic [ID_W-1:0]    wr_id,
    input  logic [IDX_W-1:0]   wr_i0,
    input  logic [IDX_W-1:0]   wr_i1,
    input  logic [IDX_W-1:0]   wr_i2,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               rsp_valid,
    output logic [DEST_W-1:0]  rsp_dest,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [ENTRY_W-1:0] rsp_entry
);
    alg_rec_t new_rec;
    alg_rec_t req_rec, wr_rec;
    logic     req_known, wr_known;
    key_t     req_key, wr_key;
    logic     fill_ok, bypass;
    logic     st_hit;
    data_t    st_data;

    always_comb begin
        new_rec.entry  = cfg_entry;
        new_rec.cfg.w0 = clamp_w(cfg_w0);
        new_rec.cfg.w1 = clamp_w(cfg_w1);
        new_rec.cfg.w2 = clamp_w(cfg_w2);
    end

    cres_alg_table #(.N_ALGS(NUM_ALGS)) u_table (
        .clk      (clk),
        .rst      (rst),
        .set_en   (cfg_valid),
        .set_id   (cfg_id),
        .set_rec  (new_rec),
        .rda_id   (req_id),
        .rda_known(req_known),
        .rda_rec  (req_rec),
        .rdb_id   (wr_id),
        .rdb_known(wr_known),
        .rdb_rec  (wr_rec)
    );

    assign req_key = make_key(req_i0, req_i1, req_i2, req_rec.cfg);
    assign wr_key  = make_key(wr_i0, wr_i1, wr_i2, wr_rec.cfg);
    assign fill_ok = wr_valid && wr_known;
    assign bypass  = fill_ok && wr_id == req_id && wr_key == req_key;

    cres_tag_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .lk_id    (req_id),
        .lk_key   (req_key),
        .lk_hit   (st_hit),
        .lk_data  (st_data),
        .fill_en  (fill_ok),
        .fill_id  (wr_id),
        .fill_key (wr_key),
        .fill_data(wr_data),
        .inv_en   (cfg_valid),
        .inv_id   (cfg_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_dest  <= '0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            rsp_entry <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_dest  <= req_valid ? req_dest : '0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            rsp_entry <= '0;
            if (req_valid) begin
                if (!req_known) begin
                    rsp_err <= 1'b1;
                end else if (bypass) begin
                    rsp_hit  <= 1'b1;
                    rsp_data <= wr_data;
                end else if (st_hit) begin
                    rsp_hit  <= 1'b1;
                    rsp_data <= st_data;
                end else begin
                    rsp_miss  <= 1'b1;
                    rsp_entry <= req_rec.entry;
                end
            end
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    dest_echo_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_dest == $past(req_dest));

    // R11
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_err}) == 1);

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_data == '0 && rsp_entry == '0));
endmodule

// File: tb/coef_result_cache_bench.sv
module coef_result_cache_bench;
    import cres_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        cfg_valid;
    logic [7:0]  cfg_id;
    logic [31:0] cfg_entry;
    logic [3:0]  cfg_w0, cfg_w1, cfg_w2;
    logic        req_valid;
    logic [5:0]  req_dest;
    logic [7:0]  req_id, req_i0, req_i1, req_i2;
    logic        wr_valid;
    logic [7:0]  wr_id, wr_i0, wr_i1, wr_i2;
    logic [31:0] wr_data;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_err;
    logic [5:0]  rsp_dest;
    logic [31:0] rsp_data, rsp_entry;

    coef_result_cache u_coef_result_cache (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_id(cfg_id), .cfg_entry(cfg_entry),
        .cfg_w0(cfg_w0), .cfg_w1(cfg_w1), .cfg_w2(cfg_w2),
        .req_valid(req_valid), .req_dest(req_dest), .req_id(req_id),
        .req_i0(req_i0), .req_i1(req_i1), .req_i2(req_i2),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_i0(wr_i0), .wr_i1(wr_i1),
        .wr_i2(wr_i2), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .rsp_entry(rsp_entry)
    );

    localparam int K_HIT = 0, K_MISS = 1, K_ERR = 2;

    typedef struct {
        int          kind;
        logic [5:0]  dest;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t       sb[$];
    int         total = 0;
    int         bad = 0;
    bit         done = 0;
    logic [5:0] dest_ctr = 6'd1;

    function automatic logic [2:0] flags_of(input int kind);
        return (kind == K_HIT) ? 3'b100 : (kind == K_MISS) ? 3'b010 : 3'b001;
    endfunction

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (!rst && rsp_valid && !done) begin
            exp_t        e;
            logic [31:0] act_val;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected response: dest=%0d exp=none", rsp_dest);
            end else begin
                e = sb.pop_front();
                act_val = rsp_hit ? rsp_data : rsp_miss ? rsp_entry : (rsp_data | rsp_entry);
                if ({rsp_hit, rsp_miss, rsp_err} != flags_of(e.kind) ||
                    rsp_dest != e.dest || act_val != e.val) begin
                    bad++;
                    $display("FAIL %s flags=%b dest=%0d val=%h exp flags=%b dest=%0d val=%h",
                             e.req, {rsp_hit, rsp_miss, rsp_err}, rsp_dest, act_val,
                             flags_of(e.kind), e.dest, e.val);
                end
            end
        end
    end

    task automatic do_cfg(input logic [7:0] id, input logic [31:0] ent,
                          input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_id = id; cfg_entry = ent;
        cfg_w0 = a; cfg_w1 = b; cfg_w2 = c;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [7:0] id, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_id = id; wr_i0 = a; wr_i1 = b; wr_i2 = c; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic set_req(input logic [7:0] id, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input int kind, input logic [31:0] v,
                           input string r);
        exp_t e;
        req_valid = 1'b1; req_dest = dest_ctr; req_id = id;
        req_i0 = a; req_i1 = b; req_i2 = c;
        e.kind = kind; e.dest = dest_ctr; e.val = v; e.req = r;
        sb.push_back(e);
        dest_ctr = dest_ctr + 6'd1;
    endtask

    task automatic do_lookup(input logic [7:0] id, input logic [7:0] a, input logic [7:0] b,
                             input logic [7:0] c, input int kind, input logic [31:0] v,
                             input string r);
        @(negedge clk);
        set_req(id, a, b, c, kind, v, r);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_fill_lookup(input logic [7:0] id, input logic [7:0] a, input logic [7:0] b,
                                  input logic [7:0] c, input logic [31:0] d, input string r);
        @(negedge clk);
        wr_valid = 1'b1; wr_id = id; wr_i0 = a; wr_i1 = b; wr_i2 = c; wr_data = d;
        set_req(id, a, b, c, K_HIT, d, r);
        @(negedge clk);
        wr_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired: act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cfg_valid = 0; cfg_id = 0; cfg_entry = 0;
        cfg_w0 = 0; cfg_w1 = 0; cfg_w2 = 0;
        req_valid = 0; req_dest = 0; req_id = 0; req_i0 = 0; req_i1 = 0; req_i2 = 0;
        wr_valid = 0; wr_id = 0; wr_i0 = 0; wr_i1 = 0; wr_i2 = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || {rsp_hit, rsp_miss, rsp_err} !== 3'b000) begin
            bad++;
            $display("FAIL R1 reset outputs: valid=%b flags=%b exp valid=0 flags=000",
                     rsp_valid, {rsp_hit, rsp_miss, rsp_err});
        end
        // R1 / R7: nothing registered after reset
        do_lookup(8'd5, 8'd1, 8'd2, 8'd3, K_ERR, 32'h0, "R1");

        // R3 then R4
        do_cfg(8'd5, 32'h0000_1000, 4'd8, 4'd8, 4'd8);
        do_lookup(8'd5, 8'd1, 8'd2, 8'd3, K_MISS, 32'h0000_1000, "R3");
        do_fill(8'd5, 8'd1, 8'd2, 8'd3, 32'hAAAA_0001);
        do_lookup(8'd5, 8'd1, 8'd2, 8'd3, K_HIT, 32'hAAAA_0001, "R4");
        do_lookup(8'd5, 8'd1, 8'd2, 8'd4, K_MISS, 32'h0000_1000, "R3");

        // R5: widths 3,2,1, stray upper bits masked
        do_cfg(8'd7, 32'h0000_2000, 4'd3, 4'd2, 4'd1);
        do_fill(8'd7, 8'd5, 8'd3, 8'd1, 32'h0000_00B7);
        do_lookup(8'd7, 8'hFD, 8'h07, 8'hFF, K_HIT, 32'h0000_00B7, "R5");
        do_lookup(8'd7, 8'd4, 8'd3, 8'd1, K_MISS, 32'h0000_2000, "R5");
        do_lookup(8'd7, 8'd5, 8'd2, 8'd1, K_MISS, 32'h0000_2000, "R5");

        // R6: width 12 clamps to 8, width 0 ignores index 1
        do_cfg(8'd9, 32'h0000_9000, 4'd12, 4'd0, 4'd8);
        do_fill(8'd9, 8'h80, 8'h55, 8'h11, 32'h0000_0999);
        do_lookup(8'd9, 8'h80, 8'hAA, 8'h11, K_HIT, 32'h0000_0999, "R6");
        do_lookup(8'd9, 8'h00, 8'h55, 8'h11, K_MISS, 32'h0000_9000, "R6");

        // R7: fill to unregistered number is discarded
        do_fill(8'd11, 8'd1, 8'd1, 8'd1, 32'h1111_1111);
        do_lookup(8'd11, 8'd1, 8'd1, 8'd1, K_ERR, 32'h0, "R7");

        // R9: same-cycle fill and lookup
        do_fill_lookup(8'd5, 8'd9, 8'd9, 8'd9, 32'h00C0_FFEE, "R9");
        do_lookup(8'd5, 8'd9, 8'd9, 8'd9, K_HIT, 32'h00C0_FFEE, "R9");

        // R8: re-registration drops only this number's entries
        do_cfg(8'd5, 32'h0000_3000, 4'd8, 4'd8, 4'd8);
        do_lookup(8'd5, 8'd1, 8'd2, 8'd3, K_MISS, 32'h0000_3000, "R8");
        do_lookup(8'd5, 8'd9, 8'd9, 8'd9, K_MISS, 32'h0000_3000, "R8");
        do_lookup(8'd7, 8'd5, 8'd3, 8'd1, K_HIT, 32'h0000_00B7, "R8");

        // R10: overwrite in place
        do_fill(8'd7, 8'd5, 8'd3, 8'd1, 32'h0000_0B70);
        do_lookup(8'd7, 8'd5, 8'd3, 8'd1, K_HIT, 32'h0000_0B70, "R10");

        // R10: round-robin eviction
        do_cfg(8'd20, 32'h0000_2020, 4'd8, 4'd8, 4'd8);
        for (int k = 0; k < 16; k++)
            do_fill(8'd20, 8'(k), 8'd0, 8'd0, 32'h2000_0000 + 32'(k));
        do_lookup(8'd20, 8'd0, 8'd0, 8'd0, K_HIT, 32'h2000_0000, "R10");
        do_lookup(8'd20, 8'd15, 8'd0, 8'd0, K_HIT, 32'h2000_000F, "R10");
        do_fill(8'd20, 8'd16, 8'd0, 8'd0, 32'h2000_0010);
        do_lookup(8'd20, 8'd0, 8'd0, 8'd0, K_MISS, 32'h0000_2020, "R10");
        do_lookup(8'd20, 8'd1, 8'd0, 8'd0, K_HIT, 32'h2000_0001, "R10");
        do_lookup(8'd20, 8'd16, 8'd0, 8'd0, K_HIT, 32'h2000_0010, "R10");

        // R2 / R11: back-to-back requests
        @(negedge clk);
        set_req(8'd20, 8'd2, 8'd0, 8'd0, K_HIT, 32'h2000_0002, "R11");
        @(negedge clk);
        set_req(8'd42, 8'd0, 8'd0, 8'd0, K_ERR, 32'h0, "R2");
        @(negedge clk);
        req_valid = 1'b0;

        repeat (3) @(negedge clk);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2 missing responses: pending=%0d exp=0", sb.size());
        end
        finish_run();
    end
endmodule